// File: doc/BRIEF.md
# Traceback Start-State Selector

When a Viterbi decoder prunes states with a threshold, no fixed state is sure to stay alive in every cycle. The survivor memory therefore cannot begin its traceback at a hard-wired state. Instead it must be given, every cycle, the index of some state that is still alive. This block supplies that index.

The block takes one activity flag per trellis state, where a 1 means the state survived pruning. It returns the index of the lowest-numbered surviving state and a bit that says whether any state survived at all. The search is built as a recursive tree of four-input priority cells rather than one flat wide encoder. Each subtree reports a group-valid bit and a local index. The parent picks the first valid group and prefixes its two-bit group number to that group's local index. A single output register gives a fixed one-cycle latency.

Top module: `state_start_picker`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `start_state` and `any_active` are both 0, whatever the flags are.
- R2: `any_active` is 1 exactly when at least one bit of `state_flags` was 1 at the previous rising clock edge.
- R3: When no flag was set, `start_state` is 0.
- R4: When `any_active` is 1, bit `start_state` of the flags sampled at the previous edge is 1, so only a surviving state is ever selected.
- R5: When several flags are set, the smallest set bit position wins. Bit i of `state_flags` stands for state number i.
- R6: The outputs change only at a rising clock edge and show the flags captured at that edge. A change of the flags between edges leaves the outputs as they were.
- R7: The boundaries resolve correctly. All flags set gives index 0. Only the highest state (bit 255 at the default size) set gives index 255 with `any_active` equal to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| state_flags | input | NUM_STATES (256) | One survival flag per state; bit i is state i |
| start_state | output | log2(NUM_STATES) (8) | Registered index of the lowest surviving state |
| any_active | output | 1 | Registered: at least one state survived |

## Verification
Two things can fall in the same cycle: a new flag vector reaching the input, and the previous result still being held at the output. Before each rising edge the bench changes the flags and checks that the outputs still match the earlier vector. It then checks them again against a linear-scan reference just after the edge. The second pairing is the loss of every survivor together with the index being forced to zero. The bench provokes it by going straight from dense or all-ones patterns to an all-clear vector, and it judges that both outputs drop to 0 on the same edge.

// File: rtl/pe_pkg.sv
package pe_pkg;
    // Fan-in of one priority cell in the tree.
    localparam int unsigned PE_CELL_WAYS  = 4;
    localparam int unsigned PE_CELL_BITS  = $clog2(PE_CELL_WAYS);
    // Default trellis size (constraint length 9 gives 256 states).
    localparam int unsigned PE_DEF_STATES = 256;

    typedef logic [PE_CELL_BITS-1:0] cell_idx_t;
endpackage

// File: rtl/pe4_cell.sv
module pe4_cell
    import pe_pkg::*;
(
    input  logic [PE_CELL_WAYS-1:0] req,
    output logic                    vld,
    output cell_idx_t               idx
);
    // The lowest request wins. The index stays 0 when nothing is requested.
    always_comb begin
        vld = |req;
        idx = '0;
        for (int i = PE_CELL_WAYS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = cell_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/pe_tree.sv
module pe_tree
    import pe_pkg::*;
#(
    parameter  int unsigned WIDTH = PE_DEF_STATES,
    localparam int unsigned IW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] flags,
    output logic             vld,
    output logic [IW-1:0]    idx
);
    generate
        if (WIDTH == PE_CELL_WAYS) begin : g_leaf
            pe4_cell u_cell (
                .req (flags),
                .vld (vld),
                .idx (idx)
            );
        end else begin : g_node
            localparam int unsigned SUB = WIDTH / PE_CELL_WAYS;
            localparam int unsigned SW  = IW - PE_CELL_BITS;

            logic [PE_CELL_WAYS-1:0]         sub_vld;
            logic [PE_CELL_WAYS-1:0][SW-1:0] sub_idx;
            cell_idx_t                       grp;

            for (genvar g = 0; g < PE_CELL_WAYS; g++) begin : g_sub
                pe_tree #(.WIDTH(SUB)) u_sub (
                    .flags (flags[g*SUB +: SUB]),
                    .vld   (sub_vld[g]),
                    .idx   (sub_idx[g])
                );
            end

            // Pick the first group that reports a survivor.
            pe4_cell u_sel (
                .req (sub_vld),
                .vld (vld),
                .idx (grp)
            );

            assign idx = {grp, sub_idx[grp]};
        end
    endgenerate
endmodule

// File: rtl/state_start_picker.sv
module state_start_picker
    import pe_pkg::*;
#(
    parameter  int unsigned NUM_STATES = PE_DEF_STATES,
    localparam int unsigned IDX_W      = $clog2(NUM_STATES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STATES-1:0] state_flags,
    output logic [IDX_W-1:0]      start_state,
    output logic                  any_active
);
    logic             tree_vld;
    logic [IDX_W-1:0] tree_idx;

    pe_tree #(.WIDTH(NUM_STATES)) u_tree (
        .flags (state_flags),
        .vld   (tree_vld),
        .idx   (tree_idx)
    );

    // Output register. The index is forced to zero when nothing survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_state <= '0;
            any_active  <= 1'b0;
        end else begin
            any_active  <= tree_vld;
            start_state <= tree_vld ? tree_idx : '0;
        end
    end
endmodule

// File: rtl/state_start_picker_chk.sv
module state_start_picker_chk #(
    parameter  int unsigned NUM_STATES = 256,
    localparam int unsigned IDX_W      = $clog2(NUM_STATES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_STATES-1:0] state_flags,
    input logic [IDX_W-1:0]      start_state,
    input logic                  any_active
);
    logic [NUM_STATES-1:0] flags_q;
    logic [NUM_STATES-1:0] below_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= state_flags;
    end

    assign below_mask = ({{(NUM_STATES-1){1'b0}}, 1'b1} << start_state) - 1'b1;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (start_state == '0 && !any_active)); // R1

    AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        any_active == (flags_q != '0)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !any_active |-> start_state == '0); // R3

    AST_PICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |-> flags_q[start_state]); // R4

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |-> (flags_q & below_mask) == '0); // R5
endmodule

bind state_start_picker state_start_picker_chk #(.NUM_STATES(NUM_STATES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_flags (state_flags),
    .start_state (start_state),
    .any_active  (any_active)
);

// File: tb/tb_state_start_picker.sv
module tb_state_start_picker;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 256;
    localparam int IW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  flags = '0;
    logic [IW-1:0] start_state;
    logic          any_active;

    int checks = 0;
    int errors = 0;
    int prev_idx = 0;
    int prev_any = 0;
    bit done = 0;

    state_start_picker dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_flags (flags),
        .start_state (start_state),
        .any_active  (any_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: plain linear scan from state 0 upward.
    function automatic int scan_lowest(input logic [N-1:0] f);
        for (int i = 0; i < N; i++) if (f[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] rand_vec();
        logic [N-1:0] v;
        for (int w = 0; w < N/32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    // Drive between edges, confirm the hold (R6), then check after the edge.
    task automatic apply(input logic [N-1:0] f, input string tag);
        int e;
        @(negedge clk);
        flags = f;
        #1;
        check(start_state == IW'(prev_idx), "R6 hold idx", int'(start_state), prev_idx);
        check(int'(any_active) == prev_any, "R6 hold any", int'(any_active), prev_any);
        @(posedge clk);
        #1;
        e = scan_lowest(f);
        prev_any = (e >= 0) ? 1 : 0;
        prev_idx = (e >= 0) ? e : 0;
        check(int'(any_active) == prev_any, {tag, " any"}, int'(any_active), prev_any);
        check(int'(start_state) == prev_idx, {tag, " idx"}, int'(start_state), prev_idx);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with flags present
        flags = {N{1'b1}};
        repeat (3) @(posedge clk);
        #1;
        check(start_state == '0, "R1 reset idx", int'(start_state), 0);
        check(any_active == 1'b0, "R1 reset any", int'(any_active), 0);
        @(negedge clk);
        rst_n = 1'b1;
        flags = '0;
        prev_idx = 0;
        prev_any = 0;

        apply('0, "R2 R3 all-zero");
        apply({N{1'b1}}, "R7 all-one");
        apply('0, "R3 drop from all-one");
        for (int i = 0; i < N; i++) begin
            apply({{(N-1){1'b0}}, 1'b1} << i, "R4 R7 one-hot");
        end
        apply({1'b1, {(N-1){1'b0}}}, "R7 top only");
        for (int k = 0; k < 1500; k++) begin
            apply(rand_vec(), "R2 R4 R5 random");
        end
        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] v;
            v = rand_vec() & rand_vec() & rand_vec() & rand_vec() & rand_vec();
            if (k % 5 == 0) v = '0;
            apply(v, "R3 R5 sparse");
        end
        for (int k = 0; k < 100; k++) begin
            int hi;
            hi = $urandom_range(N-1, 0);
            apply(({{(N-1){1'b0}}, 1'b1} << hi) | (rand_vec() & ({N{1'b1}} << hi)),
                  "R5 lowest-of-upper");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule